// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Receiver

The block turns a two-channel serial audio stream into parallel samples. It watches an external bit clock, a channel-select (LR) clock and a serial data line, oversampling all three with the system clock, and it assembles one left and one right sample per frame. Four framing formats share one shift engine: I2S, left-justified, right-justified and a DSP-style format in which a short frame pulse marks each channel slot. The word length is selectable, and the polarity of each incoming clock can be inverted.

Each channel period is 32 bit clocks long, so the bit clock runs at 64 times the sample rate. In the DSP format the frame pulse recurs at twice the sample rate, once per channel slot. Because that pulse does not say which channel follows, the block tracks the order itself. A completed stereo pair is shown on the outputs with a one-cycle strobe. The pair stays on the outputs until the next pair completes.

Top module: `stereo_serial_rx`

## Requirements
- R1: While reset is asserted, and after it is released, `valid_out` is 0 and both sample outputs read 0 until the first pair completes.
- R2: With `fmt` = 00 (I2S, the all-zero code), the left channel is the period in which the effective LR clock is low. The MSB is the second bit clocked in after an LR transition.
- R3: With `fmt` = 01 (left-justified), the left channel is the period in which the effective LR clock is high. The MSB is the first bit clocked in after an LR transition.
- R4: With `fmt` = 10 (right-justified), LR has the same meaning as in R3, and the LSB is the 32nd (last) bit of the channel period. Bits before the word are ignored.
- R5: With `fmt` = 11 (DSP), each rising edge of the effective LR clock starts a 32-bit channel slot, and the MSB is the bit sampled with the pulse high. The first slot after reset is left, and later slots alternate right, left, and so on.
- R6: `wlen` sets the word length: 00 = 24, 01 = 20, 10 = 18, 11 = 16 bits. Data arrives MSB first, and the word is left-aligned in the 24-bit output with zero in the unused low bits. Bits outside the word are ignored.
- R7: `lr_inv` = 1 inverts the meaning of the LR clock level. `bclk_inv` = 1 makes the block sample data on falling instead of rising bit-clock edges.
- R8: When the right sample completes, `left_out` and `right_out` update together and `valid_out` pulses for exactly one system clock. The outputs then hold until the next completion.
- R9: After reset, no sample is produced until an LR transition (a rising edge in DSP mode) has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt | input | 2 | Format: 00 I2S, 01 left-justified, 10 right-justified, 11 DSP |
| wlen | input | 2 | Word length code (see R6) |
| lr_inv | input | 1 | Invert LR clock polarity |
| bclk_inv | input | 1 | Sample on falling bit-clock edges |
| sclk_in | input | 1 | Serial bit clock |
| wsel_in | input | 1 | LR (channel select / frame) clock |
| sdata_in | input | 1 | Serial data |
| left_out | output | 24 | Left sample, left-aligned |
| right_out | output | 24 | Right sample, left-aligned |
| valid_out | output | 1 | One-cycle strobe when a new pair is shown |

## Verification
The assertions check four things on every cycle:
- the strobe is a single-cycle pulse;
- the outputs stay unchanged between strobes;
- the bits below the chosen word length are zero;
- every strobe lands a fixed number of system clocks after an effective bit-clock edge at the pins.

Only the bench scenarios can show the things that depend on the format and on serial data:
- where the word sits in each format;
- that DSP slots alternate starting with left;
- that the noise bits around the word are discarded under every polarity combination;
- that nothing is produced before the first LR transition.

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx #(
  parameter int MAX_W = 24,
  parameter int SLOT  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       fmt,
  input  logic [1:0]       wlen,
  input  logic             lr_inv,
  input  logic             bclk_inv,
  input  logic             sclk_in,
  input  logic             wsel_in,
  input  logic             sdata_in,
  output logic [MAX_W-1:0] left_out,
  output logic [MAX_W-1:0] right_out,
  output logic             valid_out
);
  localparam int CW = $clog2(2 * SLOT);
  localparam logic [CW:0] MW = (CW+1)'(MAX_W);
  localparam logic [CW:0] SL = (CW+1)'(SLOT);

  logic [2:0]       bsync;
  logic [1:0]       lsync, dsync;
  logic             lr_prev, cur_left, next_left;
  logic [CW-1:0]    cnt;
  logic [MAX_W-1:0] sh, left_hold;
  logic [CW:0]      w, start;

  wire tick   = (bsync[1] ^ bclk_inv) & ~(bsync[2] ^ bclk_inv);
  wire lr     = lsync[1] ^ lr_inv;
  wire d      = dsync[1];
  wire dsp    = (fmt == 2'b11);
  wire lr_edge = dsp ? (lr & ~lr_prev) : (lr ^ lr_prev);
  wire [CW-1:0] idx = lr_edge ? '0 : cnt;
  wire [CW:0]   pos = {1'b0, idx};
  wire in_win = (pos >= start) && (pos < start + w);
  wire last   = in_win && (pos == start + w - 1'b1);
  wire is_left = dsp ? cur_left : (lr ^ (fmt == 2'b00));
  wire [MAX_W-1:0] word = {sh[MAX_W-2:0], d} << (MW - w);

  always_comb begin
    case (wlen)
      2'b00:   w = MW;
      2'b01:   w = (CW+1)'(20);
      2'b10:   w = (CW+1)'(18);
      default: w = (CW+1)'(16);
    endcase
    case (fmt)
      2'b00:   start = (CW+1)'(1);
      2'b10:   start = SL - w;
      default: start = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bsync     <= '0;
      lsync     <= '0;
      dsync     <= '0;
      lr_prev   <= 1'b0;
      cnt       <= '1;
      sh        <= '0;
      cur_left  <= 1'b1;
      next_left <= 1'b1;
      left_hold <= '0;
      left_out  <= '0;
      right_out <= '0;
      valid_out <= 1'b0;
    end else begin
      bsync     <= {bsync[1:0], sclk_in};
      lsync     <= {lsync[0], wsel_in};
      dsync     <= {dsync[0], sdata_in};
      valid_out <= 1'b0;
      if (tick) begin
        lr_prev <= lr;
        cnt     <= (idx == '1) ? idx : idx + 1'b1;
        if (in_win) sh <= {sh[MAX_W-2:0], d};
        if (lr_edge && dsp) begin
          cur_left  <= next_left;
          next_left <= ~next_left;
        end
        if (last) begin
          if (is_left) left_hold <= word;
          else begin
            left_out  <= left_hold;
            right_out <= word;
            valid_out <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/stereo_serial_rx_chk.sv
module stereo_serial_rx_chk #(
  parameter int MAX_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       wlen,
  input logic             bclk_inv,
  input logic             sclk_in,
  input logic [MAX_W-1:0] left_out,
  input logic [MAX_W-1:0] right_out,
  input logic             valid_out
);
  function automatic logic [MAX_W-1:0] pad_mask(input logic [1:0] c);
    case (c)
      2'b00:   return '0;
      2'b01:   return {MAX_W{1'b1}} >> 20;
      2'b10:   return {MAX_W{1'b1}} >> 18;
      default: return {MAX_W{1'b1}} >> 16;
    endcase
  endfunction

  p_reset_clears_r1: assert property (@(posedge clk)
    !rst_n |=> (!valid_out && left_out == '0 && right_out == '0));

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |=> !valid_out);

  p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_out |-> ($stable(left_out) && $stable(right_out)));

  p_pad_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> (((left_out | right_out) & pad_mask(wlen)) == '0));

  p_after_bit_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> ($past(sclk_in ^ bclk_inv, 3) && !$past(sclk_in ^ bclk_inv, 4)));
endmodule

bind stereo_serial_rx stereo_serial_rx_chk #(.MAX_W(MAX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wlen(wlen), .bclk_inv(bclk_inv), .sclk_in(sclk_in),
  .left_out(left_out), .right_out(right_out), .valid_out(valid_out)
);

// File: tb/tb_stereo_serial_rx.sv
module tb_stereo_serial_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] fmt = 2'b00, wlen = 2'b00;
  logic lr_inv = 1'b0, bclk_inv = 1'b0;
  logic sclk_in = 1'b0, wsel_in = 1'b0, sdata_in = 1'b0;
  logic [23:0] left_out, right_out;
  logic valid_out;
  int checks = 0, errors = 0, vcount = 0;
  logic [23:0] got_l = '0, got_r = '0;
  bit done = 0;

  stereo_serial_rx dut (.*);

  always #4 clk = ~clk;

  always @(negedge clk) if (valid_out) begin
    vcount++;
    got_l = left_out;
    got_r = right_out;
  end

  // fmt, wlen, lr_inv, bclk_inv, left, right
  localparam logic [53:0] VEC [0:9] = '{
    {2'd0, 2'd0, 1'b0, 1'b0, 24'hA5C3E1, 24'h1E2D3C},
    {2'd0, 2'd3, 1'b0, 1'b0, 24'h123456, 24'hFEDCBA},
    {2'd1, 2'd1, 1'b0, 1'b0, 24'h89ABCD, 24'h765432},
    {2'd1, 2'd0, 1'b1, 1'b1, 24'hC0FFEE, 24'h0BADF0},
    {2'd2, 2'd0, 1'b0, 1'b0, 24'h5A5A5A, 24'hA5A5A5},
    {2'd2, 2'd3, 1'b0, 1'b1, 24'h13579B, 24'h2468AC},
    {2'd2, 2'd2, 1'b1, 1'b0, 24'hFFFFFF, 24'h800001},
    {2'd3, 2'd0, 1'b0, 1'b0, 24'hDEADBE, 24'h7F0001},
    {2'd3, 2'd3, 1'b1, 1'b1, 24'hCAFE12, 24'h34BEEF},
    {2'd0, 2'd2, 1'b1, 1'b1, 24'h3C3C3C, 24'hC3C3C3}
  };

  function automatic int wbits(input logic [1:0] c);
    case (c)
      2'b00: return 24;
      2'b01: return 20;
      2'b10: return 18;
      default: return 16;
    endcase
  endfunction

  function automatic string ftag(input logic [1:0] f);
    case (f)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sclk_in = bclk_inv;
    wsel_in = lr_inv;
    sdata_in = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    vcount = 0;
  endtask

  task automatic send_bit(input logic lr, input logic b);
    sclk_in = bclk_inv;
    wsel_in = lr ^ lr_inv;
    sdata_in = b;
    repeat (4) @(negedge clk);
    sclk_in = ~bclk_inv;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_slot(input bit is_l, input logic [23:0] s);
    int w, st;
    w = wbits(wlen);
    st = (fmt == 2'b00) ? 1 : (fmt == 2'b10) ? 32 - w : 0;
    for (int k = 0; k < 32; k++) begin
      logic lr, b;
      lr = (fmt == 2'b11) ? (k == 0) : ((fmt == 2'b00) ? !is_l : is_l);
      b = (k >= st && k < st + w) ? s[23 - (k - st)] : 1'b1;
      send_bit(lr, b);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %h expected %h", 24'h0, 24'h1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    check(valid_out == 1'b0, "R1 valid", {23'b0, valid_out}, 24'h0);
    check(left_out == '0 && right_out == '0, "R1 outputs", left_out | right_out, 24'h0);

    // R9: no LR transition, no output
    fmt = 2'b01;
    do_reset();
    for (int k = 0; k < 80; k++) send_bit(1'b0, 1'b1);
    repeat (20) @(negedge clk);
    check(vcount == 0, "R9 no strobe", 24'(vcount), 24'h0);
    check(left_out == '0, "R9 left", left_out, 24'h0);

    // Table: format (R2..R5), word length R6, polarity R7, pairing R8
    for (int i = 0; i < 10; i++) begin
      logic [23:0] a, b, m;
      string t;
      {fmt, wlen, lr_inv, bclk_inv, a, b} = VEC[i];
      do_reset();
      if (fmt == 2'b11) send_bit(1'b0, 1'b0);
      else send_bit(fmt == 2'b00, 1'b0);
      send_slot(1'b1, a);
      send_slot(1'b0, b);
      send_slot(1'b1, ~a);
      send_slot(1'b0, ~b);
      repeat (20) @(negedge clk);
      m = 24'hFFFFFF << (24 - wbits(wlen));
      t = $sformatf("%s R6 R7 vec%0d", ftag(fmt), i);
      check(got_l == (~a & m), {t, " left"}, got_l, ~a & m);
      check(got_r == (~b & m), {t, " right"}, got_r, ~b & m);
      check(vcount == 2, {t, " R8 strobe count"}, 24'(vcount), 24'd2);
    end

    // R8: outputs hold while no new pair arrives (last vector is I2S)
    for (int k = 0; k < 40; k++) send_bit(1'b1, 1'b0);
    repeat (20) @(negedge clk);
    check(vcount == 2, "R8 no extra strobe", 24'(vcount), 24'd2);
    check(left_out == (~24'h3C3C3C & 24'hFFFFC0), "R8 left held", left_out, ~24'h3C3C3C & 24'hFFFFC0);
    check(right_out == (~24'hC3C3C3 & 24'hFFFFC0), "R8 right held", right_out, ~24'hC3C3C3 & 24'hFFFFC0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule